// File: doc/BRIEF.md
# Ternary Wallace-Tree Multiplier

This block multiplies two unsigned base-3 numbers of M trits each and returns the full product of 2M trits, with no clock and no state. Each trit travels on two wires as a small binary number. Every digit pair a_i×b_j goes through a one-trit multiplier. That multiplier gives a product trit of weight 3^(i+j) and a binary carry of weight 3^(i+j+1). The product trits make M ternary rows and the carries make M binary rows, and the two kinds alternate.

A Wallace-style tree then shrinks these rows. The rows are taken in groups of three. In each column, a cell adds the three digits and gives one sum trit, plus a carry that moves to the next column up. When two binary rows are left over at the end of a stage, they merge into one ternary row, because their sum never goes above 2. For the default 5×5 case there are 10 rows, and the counts go 10, 7, 5, 3, 2. A ripple chain of ternary full adders then adds the last two rows. Its carry between digits is always a single bit.

Top module: `ternary_wallace_mul`

## Requirements
- R1: Each trit is carried on two wires as value 0 = `00`, 1 = `01`, 2 = `10`. Trit k of an operand sits at bits [2k+1:2k]. Trit k of the product sits at bits [2k+1:2k] of `p`. The product never contains the code `11` when both operands are valid.
- R2: For all valid operands, `p` holds the value a×b as an unsigned integer, over 2M trits. No carry leaves the top trit of the final adder.
- R3: When either operand is zero, every trit of `p` is zero.
- R4: When `b` is the value one, the low M trits of `p` equal `a` and the upper M trits are zero.
- R5: Operands of a single trit follow the digit table. 1×1 gives 1. 1×2 and 2×1 give 2. 2×2 gives 4, which is trit 1 with carry 1 in the next trit.
- R6: When `b` is a power of three, 3^k with k ≥ 1, `p` is `a` moved up by k trits, with zeros below.
- R7: The largest operands, (3^M−1)×(3^M−1), give (3^M−1)^2 with no loss in the top trit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 2*M | Multiplicand, M trits, two wires per trit |
| b | input | 2*M | Multiplier, M trits, two wires per trit |
| p | output | 4*M | Product, 2M trits, two wires per trit |

## Verification
All 243×243 operand pairs of the default 5×5 case are applied, and each product is compared with integer multiplication. Each pair is also labelled by its pattern, so that a failure points at the feature that broke:
- A zero operand catches a wrongly placed partial product.
- A unit operand checks that the product trits land in the right rows and columns.
- Single-trit operands test the digit table on its own, in particular the 2×2 carry.
- Powers of three check that the carry rows are offset by the right number of columns.
- The largest operands drive the maximum carry into the top trit of the final chain.

// File: rtl/ternary_wallace_mul.sv
module ternary_wallace_mul #(
  parameter int M = 5
) (
  input  logic [2*M-1:0] a,
  input  logic [2*M-1:0] b,
  output logic [4*M-1:0] p
);
  localparam int W = 2 * M;
  localparam int R = 2 * M;

  // sum of up to three digits -> {carry[1:0], sum trit[1:0]}
  function automatic logic [3:0] add3(input logic [1:0] x, input logic [1:0] y,
                                      input logic [1:0] z);
    logic [2:0] t;
    t = {1'b0, x} + {1'b0, y} + {1'b0, z};
    case (t)
      3'd0: add3 = 4'b00_00;
      3'd1: add3 = 4'b00_01;
      3'd2: add3 = 4'b00_10;
      3'd3: add3 = 4'b01_00;
      3'd4: add3 = 4'b01_01;
      3'd5: add3 = 4'b01_10;
      3'd6: add3 = 4'b10_00;
      default: add3 = 4'b00_00;
    endcase
  endfunction

  // one-trit multiply -> {carry bit, product trit}
  function automatic logic [2:0] tmul(input logic [1:0] x, input logic [1:0] y);
    case ({x, y})
      4'b01_01: tmul = 3'b0_01;
      4'b01_10: tmul = 3'b0_10;
      4'b10_01: tmul = 3'b0_10;
      4'b10_10: tmul = 3'b1_01;
      default:  tmul = 3'b0_00;
    endcase
  endfunction

  // row schedule after s stages: {row count, ternary-row mask}
  function automatic logic [63:0] walk(input int s);
    int n, nn, g;
    logic [31:0] t, nt;
    n = R;
    t = '0;
    for (int i = 0; i < R; i++) t[i] = (i % 2 == 0);
    for (int k = 0; k < s; k++) begin
      if (n > 2) begin
        nn = 0;
        nt = '0;
        for (g = 0; g + 3 <= n; g += 3) begin
          nt[nn]   = 1'b1;
          nt[nn+1] = (t[g] && t[g+1] && t[g+2]);
          nn += 2;
        end
        if (n - g == 2) begin
          if (!t[g] && !t[g+1]) begin
            nt[nn] = 1'b1;
            nn += 1;
          end else begin
            nt[nn]   = t[g];
            nt[nn+1] = t[g+1];
            nn += 2;
          end
        end else if (n - g == 1) begin
          nt[nn] = t[g];
          nn += 1;
        end
        n = nn;
        t = nt;
      end
    end
    walk = {n[31:0], t};
  endfunction

  function automatic int nstages();
    logic [63:0] w;
    int s;
    s = 0;
    w = walk(0);
    while (w[63:32] > 32'd2 && s < 64) begin
      s++;
      w = walk(s);
    end
    nstages = s;
  endfunction

  localparam int S = nstages();

  for (genvar s = 0; s <= S; s++) begin : stg
    logic [1:0] rw [R][W];
    if (s == 0) begin : pp
      always_comb begin
        logic [2:0] d;
        for (int r = 0; r < R; r++)
          for (int c = 0; c < W; c++) rw[r][c] = 2'b00;
        for (int i = 0; i < M; i++)
          for (int j = 0; j < M; j++) begin
            d = tmul(a[2*i +: 2], b[2*j +: 2]);
            rw[2*i][i+j]     = d[1:0];
            rw[2*i+1][i+j+1] = {1'b0, d[2]};
          end
      end
    end else begin : red
      localparam logic [63:0] PI = walk(s - 1);
      localparam int N  = int'(PI[63:32]);
      localparam logic [31:0] T = PI[31:0];
      localparam int G  = (N / 3) * 3;
      localparam int L0 = (G < R) ? G : R - 1;
      localparam int L1 = (G + 1 < R) ? G + 1 : R - 1;
      localparam bit BOTH_BIN = !T[L0] && !T[L1];
      always_comb begin
        logic [3:0] q;
        int nn;
        for (int r = 0; r < R; r++)
          for (int c = 0; c < W; c++) rw[r][c] = 2'b00;
        nn = 0;
        for (int g = 0; g + 3 <= N; g += 3) begin
          for (int c = 0; c < W; c++) begin
            q = add3(stg[s-1].rw[g][c], stg[s-1].rw[g+1][c], stg[s-1].rw[g+2][c]);
            rw[nn][c] = q[1:0];
            if (c + 1 < W) rw[nn+1][c+1] = q[3:2];
          end
          nn += 2;
        end
        if (N - G == 2) begin
          if (BOTH_BIN) begin
            for (int c = 0; c < W; c++) begin
              q = add3(stg[s-1].rw[L0][c], stg[s-1].rw[L1][c], 2'b00);
              rw[nn][c] = q[1:0];
            end
          end else begin
            for (int c = 0; c < W; c++) begin
              rw[nn][c]   = stg[s-1].rw[L0][c];
              rw[nn+1][c] = stg[s-1].rw[L1][c];
            end
          end
        end else if (N - G == 1) begin
          for (int c = 0; c < W; c++) rw[nn][c] = stg[s-1].rw[L0][c];
        end
      end
    end
  end

  logic [3:0] tail;
  logic       in_ok;

  always_comb begin
    logic cy;
    cy = 1'b0;
    tail = 4'b0;
    for (int c = 0; c < W; c++) begin
      tail = add3(stg[S].rw[0][c], stg[S].rw[1][c], {1'b0, cy});
      p[2*c +: 2] = tail[1:0];
      cy = tail[2];
    end
  end

  always_comb begin
    in_ok = 1'b1;
    for (int k = 0; k < M; k++)
      if (a[2*k +: 2] == 2'b11 || b[2*k +: 2] == 2'b11) in_ok = 1'b0;
  end

  always_comb begin
    logic bad;
    bad = 1'b0;
    for (int k = 0; k < W; k++) if (p[2*k +: 2] == 2'b11) bad = 1'b1;
    if (in_ok) begin
      // R1
      out_code_chk: assert (!bad);
      // R2
      no_overflow_chk: assert (tail[3:2] == 2'b00);
      // R3
      if (a == '0 || b == '0) zero_operand_chk: assert (p == '0);
      // R4
      if (b == {{(2*M-2){1'b0}}, 2'b01}) unit_operand_chk: assert (p == {{(2*M){1'b0}}, a});
    end
  end
endmodule

// File: tb/ternary_wallace_mul_test.sv
module ternary_wallace_mul_test;
  localparam int CLK_NS = 10;
  localparam int M = 5;
  localparam int TOP = 243;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2*M-1:0] a = '0;
  logic [2*M-1:0] b = '0;
  logic [4*M-1:0] p;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int    av;
    int    bv;
    int    exp;
    string tag;
  } item_t;
  item_t sb[$];

  ternary_wallace_mul #(.M(M)) uut (.a(a), .b(b), .p(p));

  always #(CLK_NS / 2) clk = ~clk;

  function automatic logic [2*M-1:0] enc(input int v);
    logic [2*M-1:0] r;
    int x;
    x = v;
    for (int k = 0; k < M; k++) begin
      r[2*k +: 2] = 2'(x % 3);
      x = x / 3;
    end
    return r;
  endfunction

  function automatic int dec(input logic [4*M-1:0] v);
    int r;
    r = 0;
    for (int k = 2 * M - 1; k >= 0; k--) r = r * 3 + int'(v[2*k +: 2]);
    return r;
  endfunction

  function automatic bit codes_ok(input logic [4*M-1:0] v);
    for (int k = 0; k < 2 * M; k++) if (v[2*k +: 2] == 2'b11) return 1'b0;
    return 1'b1;
  endfunction

  function automatic string pick_tag(input int x, input int y);
    if (x == 0 || y == 0) return "R3";
    if (y == 1) return "R4";
    if (x == TOP - 1 && y == TOP - 1) return "R7";
    if (x < 3 && y < 3) return "R5";
    if (y == 3 || y == 9 || y == 27 || y == 81) return "R6";
    return "R2";
  endfunction

  task automatic drive(input int x, input int y);
    item_t it;
    @(posedge clk);
    #1;
    a = enc(x);
    b = enc(y);
    it.av = x;
    it.bv = y;
    it.exp = x * y;
    it.tag = pick_tag(x, y);
    sb.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        it = sb.pop_front();
        checks++;
        if (dec(p) != it.exp) begin
          errors++;
          $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", it.tag, it.av, it.bv,
                   dec(p), it.exp);
        end
        checks++;
        if (!codes_ok(p)) begin
          errors++;
          $display("FAIL R1 a=%0d b=%0d actual=%h expected=no 11 codes", it.av, it.bv, p);
        end
      end
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-state pattern: both operands zero (R3)
    drive(0, 0);
    for (int x = 0; x < TOP; x++)
      for (int y = 0; y < TOP; y++) drive(x, y);
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    #(CLK_NS * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule